// File: doc/BRIEF.md
# Hardware Breakpoint Control Unit

This unit holds four breakpoint address slots, one packed control word and a sticky hit status word, all reached through a small indexed register port. Every cycle it may be given one access event: an address, the kind of access (instruction fetch, data read, data write, I/O read, I/O write) and its size. Each armed slot compares the event against its own address window under its own condition and length codes. Any slot that matches raises a debug-exception request in that same cycle and leaves a sticky bit in the status word.

A single configuration input, `dbg_ext_en`, decides whether I/O watchpoints can fire and how register indices 4 and 5 behave. With it low they alias the status and control words. With it high they are illegal and flag an error. An execution hit is reported as fault-like, before the instruction runs. Data and I/O hits are reported as trap-like, after the access. The surrounding core uses the `dbg_fault` output to tell the two apart.

Top module: `bkpt_unit`

## Requirements
- R1: Register indices 0 to 3 are four 64-bit slot address registers that read back what was written. After reset every slot, the status word and the control word read as zero.
- R2: Slot n is armed by control bit 2n. Its condition code sits in control bits [17+4n:16+4n] and its length code in bits [19+4n:18+4n]. A slot whose enable bit is clear never hits.
- R3: Condition 00 (execution) hits only a fetch event whose address equals the slot address exactly, and only when the slot's length code is 00. Event size is ignored for fetches.
- R4: Condition 01 hits only data-write events that overlap the slot window. Condition 11 hits data reads and data writes that overlap the window, and never fetches or I/O accesses.
- R5: Condition 10 hits I/O read or I/O write events that overlap the window, but only while `dbg_ext_en` is high. While it is low this code never hits.
- R6: Length codes map to window sizes as 00→1, 01→2, 11→4, 10→8 bytes. The window starts at the slot address with its low bits cleared to that size. Event size codes 0/1/2/3 mean 1/2/4/8 bytes, and an event hits when its byte range overlaps the window.
- R7: `hit_vec` bit n and `dbg_req` rise combinationally in the cycle the event is presented, and only while `ev_valid` is high. Several slots may hit together.
- R8: `dbg_fault` is high together with `dbg_req` when the hit comes from an execution slot, and low for data or I/O hits.
- R9: Status word (index 6) bit n is set at the clock edge that ends a cycle in which slot n hit. The hardware never clears it. A software write loads the written bits, and hits in that same cycle are ORed into them.
- R10: With `dbg_ext_en` low, index 4 reads and writes the status word and index 5 reads and writes the control word. With it high, an access to index 4 or 5 raises `reg_err` for that cycle, the write is dropped and the read returns zero.
- R11: The control word (index 7) is 32 bits wide. Its upper 32 read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_ext_en | input | 1 | Debug extensions: enables I/O conditions and makes indices 4/5 illegal |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register index 0..7 |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational, zero when not reading |
| reg_err | output | 1 | Illegal register index accessed this cycle |
| ev_valid | input | 1 | Access event present |
| ev_addr | input | 64 | Event start address |
| ev_kind | input | 3 | 0 fetch, 1 data read, 2 data write, 3 I/O read, 4 I/O write |
| ev_size | input | 2 | Event size code: 1, 2, 4 or 8 bytes |
| hit_vec | output | 4 | Per-slot hit this cycle |
| dbg_req | output | 1 | Debug-exception request pulse |
| dbg_fault | output | 1 | Request is fault-like (execution hit) |

## Verification
A wrong control-field decode or a wrong length mask shows at once on `hit_vec` in the same cycle as the offending event, as a slot that fires on the wrong kind or on an address just outside its window. The sweep walks each condition and length through a band of addresses straddling the window, so an off-by-one window edge shows within a few events. A status word that loses or invents bits shows on the first register read after the event. A wrong alias decode shows on the very access that uses index 4 or 5.

// File: rtl/bkpt_pkg.sv
// Shared encodings for the breakpoint unit: access kinds, condition codes,
// register indices and the length-code to address-mask mapping.
package bkpt_pkg;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_DRD   = 3'd1,
        ACC_DWR   = 3'd2,
        ACC_IORD  = 3'd3,
        ACC_IOWR  = 3'd4
    } acc_kind_e;

    localparam logic [1:0] COND_EXEC = 2'b00;
    localparam logic [1:0] COND_WR   = 2'b01;
    localparam logic [1:0] COND_IO   = 2'b10;
    localparam logic [1:0] COND_RW   = 2'b11;

    localparam logic [2:0] IDX_ALIAS_ST = 3'd4;
    localparam logic [2:0] IDX_ALIAS_CT = 3'd5;
    localparam logic [2:0] IDX_STATUS   = 3'd6;
    localparam logic [2:0] IDX_CTRL     = 3'd7;

    // Low-address mask of a slot window; the encoding is not monotonic.
    function automatic logic [2:0] len_mask(input logic [1:0] len);
        case (len)
            2'b00:   len_mask = 3'd0;
            2'b01:   len_mask = 3'd1;
            2'b11:   len_mask = 3'd3;
            default: len_mask = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/bkpt_slot_cmp.sv
// One breakpoint comparator. Purely combinational: decides whether the
// current event hits this slot under its condition and length codes.
// Assumes event sizes of at most 8 bytes; the range test is one bit wider
// than the address so that windows at the top of memory do not wrap.
module bkpt_slot_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              en,
    input  logic [1:0]        cond,
    input  logic [1:0]        len,
    input  logic [ADDR_W-1:0] base,
    input  logic              ext_en,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [2:0]        ev_kind,
    input  logic [1:0]        ev_size,
    output logic              hit,
    output logic              is_exec
);
    localparam int AW1 = ADDR_W + 1;

    logic [AW1-1:0] win_lo, win_hi, acc_lo, acc_hi;
    logic [AW1-1:0] mask_x;
    logic [3:0]     span;
    logic           overlap;

    // Window and access byte ranges, and their overlap.
    always_comb begin
        mask_x  = {{(AW1-3){1'b0}}, len_mask(len)};
        win_lo  = {1'b0, base} & ~mask_x;
        win_hi  = win_lo + mask_x;
        span    = (4'd1 << ev_size) - 4'd1;
        acc_lo  = {1'b0, ev_addr};
        acc_hi  = acc_lo + {{(AW1-4){1'b0}}, span};
        overlap = (acc_lo <= win_hi) && (acc_hi >= win_lo);
    end

    // Condition decode against the access kind.
    always_comb begin
        hit = 1'b0;
        if (en && ev_valid) begin
            case (cond)
                COND_EXEC: hit = (ev_kind == ACC_FETCH) && (len == 2'b00) && (ev_addr == base);
                COND_WR:   hit = (ev_kind == ACC_DWR) && overlap;
                COND_IO:   hit = ext_en && (ev_kind == ACC_IORD || ev_kind == ACC_IOWR) && overlap;
                default:   hit = (ev_kind == ACC_DRD || ev_kind == ACC_DWR) && overlap;
            endcase
        end
    end

    assign is_exec = (cond == COND_EXEC);

endmodule

// File: rtl/bkpt_regs.sv
// Register file of the breakpoint unit: slot addresses, control word and
// sticky status word, with alias/illegal handling of indices 4 and 5.
// Reads are combinational; writes take effect at the next clock edge.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int NSLOT  = 4,
    parameter int CTRL_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ext_en,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [2:0]              reg_idx,
    input  logic [ADDR_W-1:0]       reg_wdata,
    input  logic [NSLOT-1:0]        hits,
    output logic [ADDR_W-1:0]       reg_rdata,
    output logic                    reg_err,
    output logic [NSLOT*ADDR_W-1:0] slot_flat,
    output logic [CTRL_W-1:0]       ctrl,
    output logic [NSLOT-1:0]        status
);
    logic [ADDR_W-1:0] slot_q [NSLOT];
    logic [CTRL_W-1:0] ctrl_q;
    logic [NSLOT-1:0]  status_q;
    logic [2:0]        eff_idx;
    logic              illegal;
    logic              wr_ok;

    // Resolve legacy aliases and the illegal-index case.
    always_comb begin
        illegal = ext_en && (reg_idx == IDX_ALIAS_ST || reg_idx == IDX_ALIAS_CT);
        eff_idx = reg_idx;
        if (!ext_en && reg_idx == IDX_ALIAS_ST) eff_idx = IDX_STATUS;
        if (!ext_en && reg_idx == IDX_ALIAS_CT) eff_idx = IDX_CTRL;
    end

    assign wr_ok   = reg_wr && !illegal;
    assign reg_err = (reg_wr || reg_rd) && illegal;

    // Slot address registers, one per generate branch.
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                           slot_q[i] <= '0;
            else if (wr_ok && eff_idx == 3'(i))   slot_q[i] <= reg_wdata;
        end
        assign slot_flat[i*ADDR_W +: ADDR_W] = slot_q[i];
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (wr_ok && eff_idx == IDX_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    // Sticky status: software load, hardware only ORs in new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else status_q <= ((wr_ok && eff_idx == IDX_STATUS) ? reg_wdata[NSLOT-1:0] : status_q) | hits;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && !illegal) begin
            for (int i = 0; i < NSLOT; i++)
                if (eff_idx == 3'(i)) reg_rdata = slot_q[i];
            if (eff_idx == IDX_STATUS) reg_rdata = {{(ADDR_W-NSLOT){1'b0}}, status_q};
            if (eff_idx == IDX_CTRL)   reg_rdata = {{(ADDR_W-CTRL_W){1'b0}}, ctrl_q};
        end
    end

    assign ctrl   = ctrl_q;
    assign status = status_q;

    // R9: without a software write to status, no status bit ever falls.
    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !illegal && eff_idx == IDX_STATUS)
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R10: an error is reported only for indices 4/5 with extensions on.
    a_r10_err_only_alias: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (ext_en && reg_idx[2:1] == 2'b10));

endmodule

// File: rtl/bkpt_unit.sv
// Top of the hardware breakpoint unit. Extracts per-slot fields from the
// packed control word, runs one comparator per slot and combines hits into
// a same-cycle request. Assumes at most one access event per cycle.
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int NSLOT  = 4,
    parameter int CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_ext_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              reg_err,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [2:0]        ev_kind,
    input  logic [1:0]        ev_size,
    output logic [NSLOT-1:0]  hit_vec,
    output logic              dbg_req,
    output logic              dbg_fault
);
    localparam int COND_LSB = 16;
    localparam int FLD_STEP = 4;

    logic [NSLOT*ADDR_W-1:0] slot_flat;
    logic [CTRL_W-1:0]       ctrl;
    logic [NSLOT-1:0]        status;
    logic [NSLOT-1:0]        exec_vec;
    logic [NSLOT-1:0]        rw_vec;

    bkpt_regs #(.ADDR_W(ADDR_W), .NSLOT(NSLOT), .CTRL_W(CTRL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ext_en(dbg_ext_en),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .hits(hit_vec), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .slot_flat(slot_flat), .ctrl(ctrl), .status(status)
    );

    // One comparator per slot, fields taken from fixed control positions.
    for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
        bkpt_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .en(ctrl[2*i]),
            .cond(ctrl[COND_LSB + FLD_STEP*i +: 2]),
            .len(ctrl[COND_LSB + FLD_STEP*i + 2 +: 2]),
            .base(slot_flat[i*ADDR_W +: ADDR_W]),
            .ext_en(dbg_ext_en),
            .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_kind(ev_kind), .ev_size(ev_size),
            .hit(hit_vec[i]), .is_exec(exec_vec[i])
        );
        assign rw_vec[i] = (ctrl[COND_LSB + FLD_STEP*i +: 2] == COND_RW);
    end

    // Request and fault/trap classification.
    assign dbg_req   = |hit_vec;
    assign dbg_fault = |(hit_vec & exec_vec);

    // R7: a request never appears without an event.
    a_r7_req_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> ev_valid);

    // R9: every slot that hit is recorded in status one edge later.
    a_r9_req_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |=> ((status & $past(hit_vec)) == $past(hit_vec)));

    // R5: with extensions off, I/O events hit nothing.
    a_r5_io_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_ext_en && ev_valid && (ev_kind == ACC_IORD || ev_kind == ACC_IOWR))
        |-> (hit_vec == '0));

    // R4: fetch events never hit a read/write slot.
    a_r4_fetch_not_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == ACC_FETCH) |-> ((hit_vec & rw_vec) == '0));

endmodule

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_ext_en = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic        ev_valid = 1'b0;
    logic [63:0] ev_addr = '0;
    logic [2:0]  ev_kind = '0;
    logic [1:0]  ev_size = '0;
    logic [3:0]  hit_vec;
    logic        dbg_req, dbg_fault;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bkpt_unit u0 (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] i, input logic [63:0] d, output logic e);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
        #1 e = reg_err;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] i, output logic [63:0] d, output logic e);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = i;
        #1 d = reg_rdata; e = reg_err;
        reg_rd = 1'b0;
    endtask

    task automatic ev(input logic [63:0] a, input logic [2:0] k, input logic [1:0] s);
        @(negedge clk);
        ev_valid = 1'b1; ev_addr = a; ev_kind = k; ev_size = s;
        #1;
    endtask

    task automatic ev_idle();
        @(negedge clk);
        ev_valid = 1'b0;
        #1;
    endtask

    // Independent reference of one slot's hit decision.
    function automatic bit exp_hit(input bit en, input logic [1:0] cond, input logic [1:0] len,
                                   input bit ext, input logic [63:0] base, input logic [63:0] a,
                                   input logic [2:0] k, input logic [1:0] s);
        longint unsigned bytes, ws, we, ae;
        bit ov;
        bytes = (len == 2'b00) ? 1 : (len == 2'b01) ? 2 : (len == 2'b11) ? 4 : 8;
        ws = base - (base % bytes);
        we = ws + bytes - 1;
        ae = a + (64'd1 << s) - 1;
        ov = (a <= we) && (ae >= ws);
        if (!en) return 1'b0;
        case (cond)
            2'b00:   return (k == 3'd0) && (len == 2'b00) && (a == base);
            2'b01:   return (k == 3'd2) && ov;
            2'b10:   return ext && (k == 3'd3 || k == 3'd4) && ov;
            default: return (k == 3'd1 || k == 3'd2) && ov;
        endcase
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [63:0] d;
        logic        e;
        logic [63:0] base1;
        logic [3:0]  st_exp;
        string       tag;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            rd_reg(3'(i), d, e);
            check("R1 slot reset", d, 64'd0);
        end
        rd_reg(3'd6, d, e); check("R1 status reset", d, 64'd0);
        rd_reg(3'd7, d, e); check("R1 ctrl reset", d, 64'd0);
        check("R7 no request after reset", {63'd0, dbg_req}, 64'd0);

        // R1: slot read-back
        for (int i = 0; i < 4; i++) wr_reg(3'(i), 64'hA5A5_0000_0000_0000 ^ (64'(i) << 60) ^ 64'(i * 9 + 1), e);
        for (int i = 0; i < 4; i++) begin
            rd_reg(3'(i), d, e);
            check("R1 slot readback", d, 64'hA5A5_0000_0000_0000 ^ (64'(i) << 60) ^ 64'(i * 9 + 1));
        end

        // R11: control width
        wr_reg(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, e);
        rd_reg(3'd7, d, e);
        check("R11 ctrl upper zero", d, 64'h0000_0000_FFFF_FFFF);
        wr_reg(3'd7, 64'd0, e);

        // R2..R9: sweep of slot 1 over enable, ext, condition, length
        base1 = 64'hFFFF_8000_0000_1010;
        wr_reg(3'd1, base1, e);
        for (int en = 0; en < 2; en++)
        for (int ext = 0; ext < 2; ext++)
        for (int cond = 0; cond < 4; cond++)
        for (int len = 0; len < 4; len++) begin
            dbg_ext_en = ext[0];
            wr_reg(3'd7, (64'(en) << 2) | (64'(cond) << 20) | (64'(len) << 22), e);
            wr_reg(3'd6, 64'd0, e);
            st_exp = 4'd0;
            case (cond)
                0: tag = "R3 exec";
                1: tag = "R4 write";
                2: tag = "R5 io";
                default: tag = "R4 rdwr";
            endcase
            if (en == 0) tag = "R2 disabled";
            for (int off = 0; off < 24; off++)
            for (int k = 0; k < 5; k++)
            for (int s = 0; s < 4; s++) begin
                bit h;
                h = exp_hit(en[0], 2'(cond), 2'(len), ext[0], base1, base1 - 64'd8 + 64'(off), 3'(k), 2'(s));
                ev(base1 - 64'd8 + 64'(off), 3'(k), 2'(s));
                check({tag, " R6 hit_vec"}, {60'd0, hit_vec}, {60'd0, 1'b0, 1'b0, h, 1'b0});
                check("R7 dbg_req", {63'd0, dbg_req}, {63'd0, h});
                check("R8 dbg_fault", {63'd0, dbg_fault}, {63'd0, h && cond == 0});
                st_exp[1] = st_exp[1] | h;
            end
            ev_idle();
            check("R7 idle no request", {63'd0, dbg_req}, 64'd0);
            rd_reg(3'd6, d, e);
            check("R9 sticky status", d, {60'd0, st_exp});
        end

        // R7: two slots hit on one event
        dbg_ext_en = 1'b0;
        wr_reg(3'd1, 64'd0, e);
        wr_reg(3'd0, 64'h40, e);
        wr_reg(3'd2, 64'h40, e);
        wr_reg(3'd7, (64'd1 << 0) | (64'd1 << 4) | (64'h3 << 16) | (64'h3 << 18) | (64'h1 << 24) | (64'h2 << 26), e);
        wr_reg(3'd6, 64'd0, e);
        ev(64'h42, 3'd2, 2'd1);
        check("R7 two slots hit", {60'd0, hit_vec}, 64'h5);
        ev(64'h44, 3'd1, 2'd0);
        check("R4 read outside rw window", {60'd0, hit_vec}, 64'h0);
        ev_idle();
        rd_reg(3'd6, d, e);
        check("R9 both bits set", d, 64'h5);
        wr_reg(3'd6, 64'd0, e);
        rd_reg(3'd6, d, e);
        check("R9 software clear", d, 64'h0);

        // R10: aliases with extensions off
        wr_reg(3'd4, 64'hA, e);
        check("R10 alias no error", {63'd0, e}, 64'd0);
        rd_reg(3'd6, d, e);
        check("R10 index4 writes status", d, 64'hA);
        wr_reg(3'd5, 64'h0000_1234, e);
        rd_reg(3'd7, d, e);
        check("R10 index5 writes ctrl", d, 64'h0000_1234);
        rd_reg(3'd4, d, e);
        check("R10 index4 reads status", d, 64'hA);
        rd_reg(3'd5, d, e);
        check("R10 index5 reads ctrl", d, 64'h0000_1234);

        // R10: illegal with extensions on
        dbg_ext_en = 1'b1;
        wr_reg(3'd5, 64'h55, e);
        check("R10 write error", {63'd0, e}, 64'd1);
        rd_reg(3'd7, d, e);
        check("R10 write dropped", d, 64'h0000_1234);
        wr_reg(3'd4, 64'h0, e);
        rd_reg(3'd6, d, e);
        check("R10 status untouched", d, 64'hA);
        rd_reg(3'd4, d, e);
        check("R10 read error", {63'd0, e}, 64'd1);
        check("R10 read zero", d, 64'd0);

        done = 1'b1;
        summary();
    end
endmodule